// File: doc/BRIEF.md
# I2C Sub-Phase Bit Timing Generator

This block generates the SCL waveform and the SDA change point for a single I2C data bit. It runs from a free-running peripheral clock. Every SCL period is split into a low half and a high half, and each half holds eight equal sub-phases. A low divisor sets the length of a low sub-phase and a high divisor sets the length of a high sub-phase, so the two halves are tuned independently. A small update-point field picks the low sub-phase at which SDA may change. Moving that point trades data hold time (after SCL falls) against data setup time (before SCL rises).

A byte-level sequencer above this block presents a bit value, the two divisors and the update point, then raises a start strobe. The block returns a one-cycle done pulse in the last cycle of the high half. A start strobe in that same cycle chains the next bit with no gap, so consecutive bits form a continuous clock. Both bus lines are driven as open-drain enables: a 1 pulls the line low and a 0 releases it.

Top module: `i2c_subphase_bitgen`

## Requirements
- R1: After reset, `scl_pull`, `sda_pull` and `bit_done` are all 0.
- R2: A `bit_start` that is accepted while the block is idle sets `scl_pull` to 1 from the clock edge that samples it. That edge is the SCL falling point of the bit.
- R3: With l = `div_lo`+1 and h = `div_hi`+1, `scl_pull` stays 1 for 8*l cycles after the falling point and then stays 0 for 8*h cycles. One bit period is therefore 8*(l+h) cycles.
- R4: With s = `upd_pt`+1, `sda_pull` takes the value NOT `bit_val` at the clock edge l*s+1 cycles after the SCL falling point. A bit value of 1 releases SDA and a bit value of 0 pulls it low. `sda_pull` changes at no other edge of the bit and keeps its value between bits.
- R5: An `upd_pt` value above 6 is treated as 6 (s = 7). SDA therefore always changes no later than the edge on which SCL is released.
- R6: `bit_done` is 1 for exactly one cycle: the last cycle of the high half. During that cycle `scl_pull` is 0.
- R7: A `bit_start` given while `bit_done` is 1 begins the next bit at the edge that ends the current one, so SCL goes from high straight into the next low half. Without such a start, the block goes idle with SCL released and SDA unchanged.
- R8: The divisors, the update point and the bit value are sampled only when a start is accepted. Changes to them during a bit have no effect on that bit's waveform.
- R9: A `bit_start` raised while a bit is in progress, other than in the `bit_done` cycle, is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| div_lo | input | 16 | Low sub-phase divisor; each low sub-phase lasts div_lo+1 cycles |
| div_hi | input | 16 | High sub-phase divisor; each high sub-phase lasts div_hi+1 cycles |
| upd_pt | input | 3 | SDA update point; SDA changes after upd_pt+1 low sub-phases |
| bit_val | input | 1 | Bit value to place on SDA |
| bit_start | input | 1 | Start (when idle) or advance (in the done cycle) strobe |
| scl_pull | output | 1 | 1 pulls SCL low, 0 releases it |
| sda_pull | output | 1 | 1 pulls SDA low, 0 releases it |
| bit_done | output | 1 | One-cycle pulse in the last cycle of the high half |

## Verification
The bench times every edge from the SCL falling point for several divisor and update-point pairs. These include single-cycle sub-phases (divisors of 0), where an off-by-one in the counter shifts the release point or the SDA change by a whole sub-phase. The clamped update point is checked with l = 1, where the SDA change coincides with the SCL release. A design that wrapped the index instead of clamping it would move the change into the wrong sub-phase or drop it. Chained bits are checked for a missing or extra released cycle between periods. Mid-bit writes to the divisors and bit value, and a stray start strobe, would each show up as a moved SCL edge, a moved SDA change or a moved done pulse if the design were to take them in.

// File: rtl/i2c_subphase_pkg.sv
package i2c_subphase_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_LOW  = 2'd1,
      ST_HIGH = 2'd2
   } bit_state_e;
endpackage

// File: rtl/i2c_subphase_counter.sv
module i2c_subphase_counter #(
   parameter int DIV_W    = 16,
   parameter int NUM_SUB  = 8,
   localparam int PH_W    = $clog2(NUM_SUB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clear_i,
   input  logic             run_i,
   input  logic [DIV_W-1:0] div_i,
   output logic [DIV_W-1:0] cyc_o,
   output logic [PH_W-1:0]  ph_o,
   output logic             half_end_o
);
   localparam logic [PH_W-1:0] LAST_PH = PH_W'(NUM_SUB - 1);

   if (NUM_SUB < 2 || (NUM_SUB & (NUM_SUB - 1)) != 0) begin : g_bad_sub
      $error("NUM_SUB must be a power of two of at least 2");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be at least 1");
   end

   logic sub_end;
   assign sub_end    = (cyc_o == div_i);
   assign half_end_o = sub_end && (ph_o == LAST_PH);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_o <= '0;
         ph_o  <= '0;
      end else if (clear_i) begin
         cyc_o <= '0;
         ph_o  <= '0;
      end else if (run_i) begin
         if (sub_end) begin
            cyc_o <= '0;
            ph_o  <= ph_o + PH_W'(1);
         end else begin
            cyc_o <= cyc_o + DIV_W'(1);
         end
      end
   end

   AST_CYC_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      run_i |-> (cyc_o <= div_i)); // R3

endmodule

// File: rtl/i2c_sda_update.sv
module i2c_sda_update #(
   parameter int UPD_W   = 3,
   parameter int NUM_SUB = 8,
   localparam int PH_W   = $clog2(NUM_SUB),
   localparam int MAX_PT = NUM_SUB - 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [UPD_W-1:0] upd_raw_i,
   output logic [PH_W-1:0]  pt_eff_o,
   input  logic             low_i,
   input  logic [PH_W-1:0]  ph_i,
   input  logic             cyc_zero_i,
   input  logic [PH_W-1:0]  pt_lat_i,
   input  logic             val_lat_i,
   output logic             sda_pull_o
);
   if (UPD_W < 1) begin : g_bad_upd
      $error("UPD_W must be at least 1");
   end

   if (((1 << UPD_W) - 1) > MAX_PT) begin : g_clamp
      always_comb begin
         if (int'(upd_raw_i) > MAX_PT) pt_eff_o = PH_W'(MAX_PT);
         else                          pt_eff_o = PH_W'(upd_raw_i);
      end
   end else begin : g_pass
      assign pt_eff_o = PH_W'(upd_raw_i);
   end

   logic hit;
   assign hit = low_i && cyc_zero_i && (ph_i == (pt_lat_i + PH_W'(1)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   sda_pull_o <= 1'b0;
      else if (hit) sda_pull_o <= ~val_lat_i;
   end

   AST_SDA_ONLY_FROM_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !low_i |=> $stable(sda_pull_o)); // R4

   AST_PT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      int'(pt_eff_o) <= MAX_PT); // R5

endmodule

// File: rtl/i2c_subphase_bitgen.sv
module i2c_subphase_bitgen
   import i2c_subphase_pkg::*;
#(
   parameter int DIV_W   = 16,
   parameter int UPD_W   = 3,
   parameter int NUM_SUB = 8,
   localparam int PH_W   = $clog2(NUM_SUB)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] div_lo,
   input  logic [DIV_W-1:0] div_hi,
   input  logic [UPD_W-1:0] upd_pt,
   input  logic             bit_val,
   input  logic             bit_start,
   output logic             scl_pull,
   output logic             sda_pull,
   output logic             bit_done
);
   bit_state_e       state_q;
   logic [DIV_W-1:0] lo_lat, hi_lat, div_sel, cyc;
   logic [PH_W-1:0]  ph, pt_eff, pt_lat;
   logic             val_lat, half_end, accept, scl_q;

   assign bit_done = (state_q == ST_HIGH) && half_end;
   assign accept   = bit_start && ((state_q == ST_IDLE) || bit_done);
   assign div_sel  = (state_q == ST_HIGH) ? hi_lat : lo_lat;
   assign scl_pull = scl_q;

   i2c_subphase_counter #(.DIV_W(DIV_W), .NUM_SUB(NUM_SUB)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .clear_i    (accept),
      .run_i      (state_q != ST_IDLE),
      .div_i      (div_sel),
      .cyc_o      (cyc),
      .ph_o       (ph),
      .half_end_o (half_end)
   );

   i2c_sda_update #(.UPD_W(UPD_W), .NUM_SUB(NUM_SUB)) u_sda (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_raw_i  (upd_pt),
      .pt_eff_o   (pt_eff),
      .low_i      (state_q == ST_LOW),
      .ph_i       (ph),
      .cyc_zero_i (cyc == '0),
      .pt_lat_i   (pt_lat),
      .val_lat_i  (val_lat),
      .sda_pull_o (sda_pull)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         scl_q   <= 1'b0;
         lo_lat  <= '0;
         hi_lat  <= '0;
         pt_lat  <= '0;
         val_lat <= 1'b0;
      end else if (accept) begin
         state_q <= ST_LOW;
         scl_q   <= 1'b1;
         lo_lat  <= div_lo;
         hi_lat  <= div_hi;
         pt_lat  <= pt_eff;
         val_lat <= bit_val;
      end else begin
         case (state_q)
            ST_LOW: if (half_end) begin
               state_q <= ST_HIGH;
               scl_q   <= 1'b0;
            end
            ST_HIGH: if (half_end) state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   AST_FALL_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> scl_pull); // R2

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      bit_done |=> !bit_done); // R6

   AST_DONE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      bit_done |-> !scl_pull); // R6

   AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE) && !accept |=>
         $stable(lo_lat) && $stable(hi_lat) && $stable(pt_lat) && $stable(val_lat)); // R8

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      bit_start && (state_q == ST_LOW) && !half_end |=> (state_q == ST_LOW)); // R9

endmodule

// File: tb/tb_i2c_subphase_bitgen.sv
module tb_i2c_subphase_bitgen;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] div_lo = '0, div_hi = '0;
   logic [2:0]  upd_pt = '0;
   logic        bit_val = 1'b0, bit_start = 1'b0;
   logic        scl_pull, sda_pull, bit_done;

   int n_checks = 0;
   int n_fail   = 0;
   logic exp_sda = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   i2c_subphase_bitgen dut (
      .clk(clk), .rst_n(rst_n), .div_lo(div_lo), .div_hi(div_hi),
      .upd_pt(upd_pt), .bit_val(bit_val), .bit_start(bit_start),
      .scl_pull(scl_pull), .sda_pull(sda_pull), .bit_done(bit_done)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic issue(input int dl, input int dh, input int up, input bit bv);
      @(negedge clk);
      div_lo = 16'(dl); div_hi = 16'(dh); upd_pt = 3'(up); bit_val = bv;
      bit_start = 1'b1;
   endtask

   // Times one bit; n counts negedges after the edge that accepted the start.
   task automatic measure(input int dl, input int dh, input int up, input bit bv,
                          input bit chained, input bit poke, input bit stray,
                          input bit chain_next, input int ndl, input int ndh,
                          input int nup, input bit nbv);
      int l = dl + 1;
      int h = dh + 1;
      int s = ((up > 6) ? 6 : up) + 1;
      int per = 8 * (l + h);
      int first_rel = 0, rel_cnt = 0, first_chg = 0, done_n = 0, done_cnt = 0;
      bit scl1 = 1'b0;
      logic new_sda = ~bv;
      for (int n = 1; n <= per; n++) begin
         @(negedge clk);
         if (n == 1) bit_start = 1'b0;
         if (n == 1) scl1 = scl_pull;
         if (!scl_pull) begin
            rel_cnt++;
            if (first_rel == 0) first_rel = n;
         end
         if (sda_pull !== exp_sda && first_chg == 0) first_chg = n;
         if (bit_done) begin
            done_cnt++;
            done_n = n;
         end
         if (poke && n == 3) begin
            div_lo = 16'(dl + 5); div_hi = 16'(dh + 3);
            upd_pt = 3'(up ^ 1); bit_val = ~bv;
         end
         if (stray && n == 4) bit_start = 1'b1;
         if (stray && n == 5) bit_start = 1'b0;
         if (chain_next && n == per) begin
            div_lo = 16'(ndl); div_hi = 16'(ndh); upd_pt = 3'(nup); bit_val = nbv;
            bit_start = 1'b1;
         end
      end
      chk(scl1 == 1'b1, chained ? "R7" : "R2", "scl pulled after start", int'(scl1), 1);
      chk(first_rel == 8*l + 1, poke ? "R8" : "R3", "scl release cycle", first_rel, 8*l + 1);
      chk(rel_cnt == 8*h, "R3", "scl high length", rel_cnt, 8*h);
      if (new_sda !== exp_sda)
         chk(first_chg == l*s + 2, (up > 6) ? "R5" : (poke ? "R8" : "R4"),
             "sda change cycle", first_chg, l*s + 2);
      else
         chk(first_chg == 0, "R4", "sda unchanged for equal value", first_chg, 0);
      chk(sda_pull === new_sda, "R4", "sda final value", int'(sda_pull), int'(new_sda));
      chk(done_n == per && done_cnt == 1, stray ? "R9" : "R6", "done cycle",
          done_n, per);
      exp_sda = new_sda;
      if (!chain_next) begin
         @(negedge clk);
         chk(scl_pull == 1'b0 && bit_done == 1'b0, "R7", "idle scl released",
             int'(scl_pull), 0);
         chk(sda_pull === exp_sda, "R7", "idle sda held", int'(sda_pull), int'(exp_sda));
      end
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(scl_pull == 0 && sda_pull == 0 && bit_done == 0, "R1", "reset outputs",
          int'({scl_pull, sda_pull, bit_done}), 0);
   endtask

   task automatic t_basic();
      issue(1, 1, 2, 1'b0); measure(1, 1, 2, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
      issue(0, 0, 0, 1'b1); measure(0, 0, 0, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_clamp();
      issue(2, 1, 7, 1'b0); measure(2, 1, 7, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
      issue(0, 0, 6, 1'b1); measure(0, 0, 6, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0);
      issue(0, 0, 7, 1'b0); measure(0, 0, 7, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_chain();
      issue(4, 2, 4, 1'b1);
      measure(4, 2, 4, 1'b1, 0, 0, 0, 1, 1, 3, 1, 1'b0);
      measure(1, 3, 1, 1'b0, 1, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_poke();
      issue(3, 2, 3, 1'b1); measure(3, 2, 3, 1'b1, 0, 1, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_stray();
      issue(1, 0, 5, 1'b0); measure(1, 0, 5, 1'b0, 0, 0, 1, 0, 0, 0, 0, 0);
   endtask

   task automatic t_same_value();
      issue(0, 1, 3, 1'b0); measure(0, 1, 3, 1'b0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   task automatic t_standard();
      issue(49, 49, 2, 1'b1); measure(49, 49, 2, 1'b1, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      t_reset();
      t_basic();
      t_clamp();
      t_chain();
      t_poke();
      t_stray();
      t_same_value();
      t_standard();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end
endmodule